// File: doc/BRIEF.md
# UDP Stream Classifier and Router

This block takes the byte stream of received Ethernet frames, after the MAC has already checked the frame check sequence. It steers each frame to one of two places. Every byte goes into a staging FIFO. While the bytes pass, the first 46 bytes are also copied into a side header buffer. When the last byte of a frame arrives, a classifier looks at the captured header. It pushes a one-entry verdict into a small verdict queue, and this happens before any byte of that frame leaves the FIFO.

A drain engine pops one verdict at a time and empties the matching frame from the FIFO, one byte per cycle:
- A frame of the selected UDP offload stream loses its Ethernet, IPv4, UDP and 4-byte stream headers. Only its payload is written to a ring buffer.
- Any other frame goes to the processor port unchanged.

The ring write pointer wraps at a run-time size. An offload frame whose payload does not fit in the free ring space is discarded whole and counted. UDP checksums are neither computed nor checked. Offload frames carry about 1 KB of payload, so standard-size frames are enough.

Top module: `udp_stream_router`

## Requirements
- R1: After reset, cpu_valid and ring_we are low, and ring_wr_ptr, ring_pkt_count and ring_ovf_count are zero.
- R2: A frame is offload traffic only when all of these hold. Byte offsets are counted from 0 at the first destination-address byte.
  - Bytes 12..13 equal 0x0800.
  - Byte 14 equals 0x45.
  - Byte 23 equals 17.
  - Bytes 36..37, high byte first, equal cfg_dport.
  - Bytes 42..43, high byte first, equal cfg_magic (this compare applies when USE_MAGIC is 1).
  - The frame is longer than 46 bytes.
- R3: A frame that is not offload traffic appears on cpu_data with every byte unchanged and in order. cpu_last marks its final byte, and frames leave in arrival order.
- R4: A frame of 46 bytes or fewer goes to the processor port, even when all of its header fields match.
- R5: For an accepted offload frame, only the bytes from offset 46 onward are written, at consecutive ring addresses starting at ring_wr_ptr. Nothing from that frame appears on the processor port, and ring_we and cpu_valid are never high together.
- R6: The ring write address wraps from cfg_ring_size-1 to 0 and always stays below cfg_ring_size.
- R7: The free space is cfg_ring_size-1 minus the occupancy (ring_wr_ptr-ring_rd_ptr, taken modulo the size).
  - An offload frame whose payload length is at most the free space is accepted; an exact fit is accepted.
  - Otherwise the frame is dropped whole: nothing is written, ring_wr_ptr does not move, and ring_ovf_count rises by one.
- R8: ring_pkt_count rises by one for each accepted offload frame, and changes at no other time.
- R9: Frames presented back to back, with no idle cycle between them, are each routed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dport | input | 16 | UDP destination port of the offload stream |
| cfg_magic | input | 16 | Expected stream-header tag |
| cfg_ring_size | input | RING_AW+1 | Ring size in bytes (1..2^RING_AW) |
| ring_rd_ptr | input | RING_AW | Consumer read position in the ring |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| cpu_valid | output | 1 | Processor port byte valid |
| cpu_data | output | 8 | Processor port byte |
| cpu_last | output | 1 | Final byte of the forwarded frame |
| ring_we | output | 1 | Ring write strobe |
| ring_addr | output | RING_AW | Ring write address |
| ring_data | output | 8 | Ring write byte |
| ring_wr_ptr | output | RING_AW | Next ring write position |
| ring_pkt_count | output | CNT_W | Accepted offload frames |
| ring_ovf_count | output | CNT_W | Offload frames dropped for lack of room |

## Verification
The bench walks a table of frames in which exactly one header field at a time is spoiled. A classifier that ignored any one of the compares would send that frame to the ring instead of the processor port. A 46-byte frame whose fields all match checks the length guard; a design that classified on an incomplete header would offload it with an empty payload. A small ring is then filled so that a payload crosses the wrap point. After that the bench sends one payload one byte too large and one that fits exactly. An off-by-one in the free-space test would accept the first or drop the second, and a wrong wrap would write past the size. Three frames are then sent with no gap between them, which exposes a verdict queue or drain engine that mixes up frame boundaries.

// File: rtl/udpr_pkg.sv
package udpr_pkg;
   localparam int LEN_W      = 16;
   localparam int HDR_BYTES  = 46;
   localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);
   localparam int OFS_ETYPE  = 12;
   localparam int OFS_VERIHL = 14;
   localparam int OFS_PROTO  = 23;
   localparam int OFS_DPORT  = 36;
   localparam int OFS_MAGIC  = 42;
   localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
   localparam logic [7:0]  VERIHL_PLAIN = 8'h45;
   localparam logic [7:0]  PROTO_UDP    = 8'd17;

   typedef struct packed {
      logic             offload;
      logic [LEN_W-1:0] plen;
   } verdict_t;
   localparam int VERDICT_W = $bits(verdict_t);

   typedef enum logic [1:0] {DR_IDLE, DR_CPU, DR_RING, DR_SKIP} drain_e;
endpackage

// File: rtl/udpr_fifo.sv
module udpr_fifo #(
   parameter int AW = 4,
   parameter int W  = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int DEPTH = 2 ** AW;

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp_q, rp_q;

   generate
      if (AW < 1) begin : g_bad_aw
         $error("udpr_fifo: AW must be at least 1");
      end
   endgenerate

   assign empty   = (wp_q == rp_q);
   assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign rd_data = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp_q[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_en) wp_q <= wp_q + 1'b1;
         if (rd_en) rp_q <= rp_q + 1'b1;
      end
   end

   // R9
   no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/udpr_hdr_snoop.sv
module udpr_hdr_snoop import udpr_pkg::*; #(
   parameter bit USE_MAGIC = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   input  logic [15:0] cfg_dport,
   input  logic [15:0] cfg_magic,
   output logic        dec_push,
   output verdict_t    dec
);
   localparam int HIW = $clog2(HDR_BYTES);

   logic [7:0]       hdr_q [HDR_BYTES];
   logic [LEN_W-1:0] seen_q;
   logic             in_hdr, fields_ok, magic_ok, hit;
   logic [15:0]      etype, dport;

   assign in_hdr = (seen_q < HDR_LEN);

   always_ff @(posedge clk) begin
      if (in_valid && in_hdr) hdr_q[seen_q[HIW-1:0]] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q <= '0;
      else if (in_valid) seen_q <= in_last ? '0 : seen_q + 1'b1;
   end

   assign etype = {hdr_q[OFS_ETYPE], hdr_q[OFS_ETYPE+1]};
   assign dport = {hdr_q[OFS_DPORT], hdr_q[OFS_DPORT+1]};

   generate
      if (USE_MAGIC) begin : g_magic
         assign magic_ok = ({hdr_q[OFS_MAGIC], hdr_q[OFS_MAGIC+1]} == cfg_magic);
      end else begin : g_nomagic
         logic unused_magic;
         assign unused_magic = ^cfg_magic;
         assign magic_ok = 1'b1;
      end
   endgenerate

   assign fields_ok = (etype == ETYPE_IPV4) && (hdr_q[OFS_VERIHL] == VERIHL_PLAIN)
                   && (hdr_q[OFS_PROTO] == PROTO_UDP) && (dport == cfg_dport);
   // payload of at least one byte means the whole header is already stored
   assign hit = !in_hdr && fields_ok && magic_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_push <= 1'b0;
         dec      <= '0;
      end else begin
         dec_push    <= in_valid && in_last;
         dec.offload <= hit;
         dec.plen    <= seen_q + 1'b1 - HDR_LEN;
      end
   end

   // R4
   offload_has_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_push && dec.offload) |-> (dec.plen != '0));
endmodule

// File: rtl/udpr_ring_ptr.sv
module udpr_ring_ptr #(
   parameter int RING_AW = 12,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RING_AW:0]   cfg_size,
   input  logic [RING_AW-1:0] rd_ptr,
   input  logic               adv,
   input  logic               pkt_done,
   input  logic               drop,
   output logic [RING_AW-1:0] wr_ptr,
   output logic [RING_AW:0]   free,
   output logic [CNT_W-1:0]   pkt_count,
   output logic [CNT_W-1:0]   ovf_count
);
   logic [RING_AW:0] wr_x, rd_x, used, wr_inc;

   assign wr_x   = {1'b0, wr_ptr};
   assign rd_x   = {1'b0, rd_ptr};
   assign used   = (wr_x >= rd_x) ? (wr_x - rd_x) : (wr_x + cfg_size - rd_x);
   assign free   = (cfg_size == '0) ? '0 : (cfg_size - 1'b1 - used);
   assign wr_inc = wr_x + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         pkt_count <= '0;
         ovf_count <= '0;
      end else begin
         if (adv)      wr_ptr    <= (wr_inc >= cfg_size) ? '0 : wr_inc[RING_AW-1:0];
         if (pkt_done) pkt_count <= pkt_count + 1'b1;
         if (drop)     ovf_count <= ovf_count + 1'b1;
      end
   end

   // R6
   ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_size != '0) |-> (wr_x < cfg_size));
   // R7
   ovf_only_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drop |=> $stable(ovf_count));
   // R7
   drop_freezes_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(wr_ptr));
   // R8
   pkt_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_done |=> $stable(pkt_count));
endmodule

// File: rtl/udp_stream_router.sv
module udp_stream_router import udpr_pkg::*; #(
   parameter int FIFO_AW   = 11,
   parameter int DQ_AW     = 2,
   parameter int RING_AW   = 12,
   parameter int CNT_W     = 16,
   parameter bit USE_MAGIC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        cfg_dport,
   input  logic [15:0]        cfg_magic,
   input  logic [RING_AW:0]   cfg_ring_size,
   input  logic [RING_AW-1:0] ring_rd_ptr,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   output logic               cpu_valid,
   output logic [7:0]         cpu_data,
   output logic               cpu_last,
   output logic               ring_we,
   output logic [RING_AW-1:0] ring_addr,
   output logic [7:0]         ring_data,
   output logic [RING_AW-1:0] ring_wr_ptr,
   output logic [CNT_W-1:0]   ring_pkt_count,
   output logic [CNT_W-1:0]   ring_ovf_count
);
   generate
      if (RING_AW + 1 > LEN_W) begin : g_bad_ring
         $error("udp_stream_router: RING_AW too wide for the length field");
      end
      if ((2 ** FIFO_AW) < 1536) begin : g_bad_fifo
         $error("udp_stream_router: staging FIFO cannot hold a full frame");
      end
   endgenerate

   logic                 dec_push, dq_empty, dq_full, dq_pop;
   verdict_t             dec, head;
   logic [VERDICT_W-1:0] dq_rd_data;
   logic                 df_empty, df_full, df_pop;
   logic [8:0]           df_rd_data;
   logic                 b_last, fits, to_ring, pkt_done, drop;
   logic [7:0]           b_data;
   logic [RING_AW:0]     free;
   logic [LEN_W-1:0]     idx_q;
   drain_e               st_q;

   udpr_hdr_snoop #(.USE_MAGIC(USE_MAGIC)) u_snoop (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .cfg_dport(cfg_dport), .cfg_magic(cfg_magic), .dec_push(dec_push), .dec(dec));

   udpr_fifo #(.AW(FIFO_AW), .W(9)) u_frame_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data({in_last, in_data}),
      .rd_en(df_pop), .rd_data(df_rd_data), .empty(df_empty), .full(df_full));

   udpr_fifo #(.AW(DQ_AW), .W(VERDICT_W)) u_verdict_q (
      .clk(clk), .rst_n(rst_n), .wr_en(dec_push), .wr_data(dec),
      .rd_en(dq_pop), .rd_data(dq_rd_data), .empty(dq_empty), .full(dq_full));

   udpr_ring_ptr #(.RING_AW(RING_AW), .CNT_W(CNT_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_ring_size), .rd_ptr(ring_rd_ptr),
      .adv(to_ring), .pkt_done(pkt_done), .drop(drop), .wr_ptr(ring_wr_ptr),
      .free(free), .pkt_count(ring_pkt_count), .ovf_count(ring_ovf_count));

   assign head            = verdict_t'(dq_rd_data);
   assign {b_last, b_data} = df_rd_data;
   assign fits            = (head.plen <= LEN_W'(free));
   assign dq_pop          = (st_q == DR_IDLE) && !dq_empty;
   assign df_pop          = (st_q != DR_IDLE) && !df_empty;
   assign to_ring         = df_pop && (st_q == DR_RING) && (idx_q >= HDR_LEN);
   assign pkt_done        = df_pop && (st_q == DR_RING) && b_last;
   assign drop            = dq_pop && head.offload && !fits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= DR_IDLE;
         idx_q <= '0;
      end else if (dq_pop) begin
         idx_q <= '0;
         st_q  <= !head.offload ? DR_CPU : (fits ? DR_RING : DR_SKIP);
      end else if (df_pop) begin
         idx_q <= idx_q + 1'b1;
         if (b_last) st_q <= DR_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_valid <= 1'b0;
         cpu_data  <= '0;
         cpu_last  <= 1'b0;
         ring_we   <= 1'b0;
         ring_addr <= '0;
         ring_data <= '0;
      end else begin
         cpu_valid <= df_pop && (st_q == DR_CPU);
         cpu_data  <= b_data;
         cpu_last  <= df_pop && (st_q == DR_CPU) && b_last;
         ring_we   <= to_ring;
         ring_addr <= ring_wr_ptr;
         ring_data <= b_data;
      end
   end

   // R5
   route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_valid, ring_we}));
   // R3
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_last |-> cpu_valid);
   // R9
   frame_fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !df_full);
   // R9
   verdict_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_push |-> !dq_full);
endmodule

// File: tb/udp_stream_router_tb.sv
module udp_stream_router_tb;
   localparam int CLK_NS = 10;
   localparam int RAW    = 12;
   localparam int RSZ    = 2 ** RAW;

   typedef struct packed {
      logic [15:0] et;
      logic [7:0]  vh;
      logic [7:0]  pr;
      logic [15:0] port;
      logic [15:0] mg;
      logic [15:0] plen;
      logic        off;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 16'd16,   1'b1},
      '{16'h86DD, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 16'd16,   1'b0},
      '{16'h0800, 8'h45, 8'd6,  16'h1F90, 16'hC0DE, 16'd20,   1'b0},
      '{16'h0800, 8'h45, 8'd17, 16'h1F91, 16'hC0DE, 16'd12,   1'b0},
      '{16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DF, 16'd9,    1'b0},
      '{16'h0800, 8'h46, 8'd17, 16'h1F90, 16'hC0DE, 16'd14,   1'b0},
      '{16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 16'd1024, 1'b1},
      '{16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 16'd1,    1'b1}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [15:0]    cfg_dport = 16'h1F90;
   logic [15:0]    cfg_magic = 16'hC0DE;
   logic [RAW:0]   cfg_ring_size = 13'(RSZ);
   logic [RAW-1:0] ring_rd_ptr = '0;
   logic           in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]     in_data = '0;
   logic           cpu_valid, cpu_last, ring_we;
   logic [7:0]     cpu_data, ring_data;
   logic [RAW-1:0] ring_addr, ring_wr_ptr;
   logic [15:0]    ring_pkt_count, ring_ovf_count;

   udp_stream_router u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_dport(cfg_dport), .cfg_magic(cfg_magic),
      .cfg_ring_size(cfg_ring_size), .ring_rd_ptr(ring_rd_ptr),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .cpu_valid(cpu_valid), .cpu_data(cpu_data), .cpu_last(cpu_last),
      .ring_we(ring_we), .ring_addr(ring_addr), .ring_data(ring_data),
      .ring_wr_ptr(ring_wr_ptr), .ring_pkt_count(ring_pkt_count),
      .ring_ovf_count(ring_ovf_count));

   always #(CLK_NS/2) clk = ~clk;

   int checks = 0, failures = 0;
   logic [7:0] frm [2048];
   int frm_len;
   logic [7:0] exp_cpu [8192];
   logic [7:0] got_cpu [8192];
   logic [7:0] exp_ring [RSZ];
   logic [7:0] got_ring [RSZ];
   int exp_cpu_n, got_cpu_n, exp_lasts, got_lasts;
   int exp_wr, exp_pkts, exp_ovf, size_b, rd_b;

   always @(negedge clk) begin
      if (cpu_valid) begin
         got_cpu[got_cpu_n % 8192] = cpu_data;
         got_cpu_n++;
         if (cpu_last) got_lasts++;
      end
      if (ring_we) got_ring[ring_addr] = ring_data;
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic clear_models();
      for (int i = 0; i < RSZ; i++) begin
         exp_ring[i] = '0;
         got_ring[i] = '0;
      end
      exp_cpu_n = 0; got_cpu_n = 0; exp_lasts = 0; got_lasts = 0;
      exp_wr = 0; exp_pkts = 0; exp_ovf = 0;
   endtask

   task automatic do_reset(input int size);
      rst_n = 1'b0;
      size_b = size; rd_b = 0;
      cfg_ring_size = 13'(size);
      ring_rd_ptr = '0;
      clear_models();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic mk(input logic [15:0] et, input logic [7:0] vh, input logic [7:0] pr,
                     input logic [15:0] port, input logic [15:0] mg, input int plen, input int seed);
      frm_len = 46 + plen;
      for (int i = 0; i < frm_len; i++) frm[i] = 8'(i * 7 + seed);
      frm[12] = et[15:8]; frm[13] = et[7:0]; frm[14] = vh; frm[23] = pr;
      frm[36] = port[15:8]; frm[37] = port[7:0]; frm[42] = mg[15:8]; frm[43] = mg[7:0];
   endtask

   // model of R2..R8 from the requirement text
   task automatic expect_frame(input bit match);
      int used, free, plen;
      plen = frm_len - 46;
      if (match && plen > 0) begin
         used = (exp_wr - rd_b + size_b) % size_b;
         free = size_b - 1 - used;
         if (plen <= free) begin
            for (int k = 0; k < plen; k++) begin
               exp_ring[exp_wr] = frm[46 + k];
               exp_wr = (exp_wr + 1) % size_b;
            end
            exp_pkts++;
         end else exp_ovf++;
      end else begin
         for (int k = 0; k < frm_len; k++) exp_cpu[(exp_cpu_n + k) % 8192] = frm[k];
         exp_cpu_n += frm_len;
         exp_lasts++;
      end
   endtask

   task automatic send(input bit idle_after);
      for (int i = 0; i < frm_len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = frm[i]; in_last = (i == frm_len - 1);
      end
      if (idle_after) begin
         @(negedge clk);
         in_valid = 1'b0; in_last = 1'b0;
      end
   endtask

   task automatic settle(input int n);
      repeat (n + 40) @(negedge clk);
   endtask

   task automatic seg_check(input string ctx);
      int bad;
      chk(got_cpu_n == exp_cpu_n, {"R3 cpu byte count ", ctx}, got_cpu_n, exp_cpu_n);
      bad = 0;
      for (int i = 0; i < exp_cpu_n && i < 8192; i++) if (got_cpu[i] !== exp_cpu[i]) bad++;
      chk(bad == 0, {"R3 cpu byte mismatches ", ctx}, bad, 0);
      chk(got_lasts == exp_lasts, {"R3 cpu_last count ", ctx}, got_lasts, exp_lasts);
      chk(int'(ring_wr_ptr) == exp_wr, {"R6 ring_wr_ptr ", ctx}, ring_wr_ptr, exp_wr);
      chk(int'(ring_pkt_count) == exp_pkts, {"R8 pkt count ", ctx}, ring_pkt_count, exp_pkts);
      chk(int'(ring_ovf_count) == exp_ovf, {"R7 ovf count ", ctx}, ring_ovf_count, exp_ovf);
      bad = 0;
      for (int i = 0; i < RSZ; i++) if (got_ring[i] !== exp_ring[i]) bad++;
      chk(bad == 0, {"R5 ring content mismatches ", ctx}, bad, 0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pk0;
      do_reset(RSZ);
      // R1 reset state
      chk(cpu_valid == 1'b0, "R1 cpu_valid after reset", cpu_valid, 0);
      chk(ring_we == 1'b0, "R1 ring_we after reset", ring_we, 0);
      chk(ring_wr_ptr == '0, "R1 ring_wr_ptr after reset", ring_wr_ptr, 0);
      chk(ring_pkt_count == '0, "R1 pkt count after reset", ring_pkt_count, 0);
      chk(ring_ovf_count == '0, "R1 ovf count after reset", ring_ovf_count, 0);

      // table of frames: one header field spoiled at a time (R2)
      for (int v = 0; v < 8; v++) begin
         pk0 = int'(ring_pkt_count);
         mk(VEC[v].et, VEC[v].vh, VEC[v].pr, VEC[v].port, VEC[v].mg, int'(VEC[v].plen), v * 13);
         expect_frame(VEC[v].off);
         send(1'b1);
         settle(frm_len);
         chk(int'(ring_pkt_count) - pk0 == int'(VEC[v].off), $sformatf("R2 routing vector %0d", v),
             int'(ring_pkt_count) - pk0, int'(VEC[v].off));
      end
      seg_check("after vector table");

      // R4: all fields match but no payload byte
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 0, 99);
      expect_frame(1'b1);
      send(1'b1);
      settle(frm_len);
      chk(got_lasts == exp_lasts, "R4 46-byte frame to processor port", got_lasts, exp_lasts);
      seg_check("after short frame");

      // R6 wrap, R7 drop and exact fit on a 1500-byte ring
      do_reset(1500);
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 1000, 3);
      expect_frame(1'b1); send(1'b1); settle(frm_len);
      rd_b = 1000; ring_rd_ptr = 12'd1000;
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 1000, 5);
      expect_frame(1'b1); send(1'b1); settle(frm_len);
      chk(int'(ring_wr_ptr) == 500, "R6 pointer wrapped", ring_wr_ptr, 500);
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 500, 8);
      expect_frame(1'b1); send(1'b1); settle(frm_len);
      chk(int'(ring_ovf_count) == 1, "R7 one byte over free space dropped", ring_ovf_count, 1);
      chk(int'(ring_wr_ptr) == 500, "R7 pointer held on drop", ring_wr_ptr, 500);
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 499, 11);
      expect_frame(1'b1); send(1'b1); settle(frm_len);
      chk(int'(ring_wr_ptr) == 999, "R7 exact fit accepted", ring_wr_ptr, 999);
      seg_check("after wrap and drop");

      // R9 three frames with no gap
      rd_b = 999; ring_rd_ptr = 12'd999;
      @(negedge clk);
      mk(16'h0801, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 20, 21);
      expect_frame(1'b0); send(1'b0);
      mk(16'h0800, 8'h45, 8'd17, 16'h1F90, 16'hC0DE, 30, 33);
      expect_frame(1'b1); send(1'b0);
      mk(16'h0800, 8'h45, 8'd17, 16'h1F92, 16'hC0DE, 5, 45);
      expect_frame(1'b0); send(1'b1);
      settle(200);
      chk(got_lasts == exp_lasts, "R9 back-to-back frame count", got_lasts, exp_lasts);
      seg_check("after back-to-back");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule